// File: doc/BRIEF.md
# Serial Flash Clock and Select Timing Generator

This block produces the serial clock and the four active-low device-select lines of a serial flash port from a faster reference clock. A transfer engine asks for a transfer with a one-cycle start pulse and a target select value. The block then waits until the select line has been high for long enough. It lowers the select and waits a programmable lead-in time. It then toggles the clock until the engine marks the current bit as the last one, waits a programmable tail time, and raises the select again. A one-cycle tick on each trailing clock edge lets the engine count bits. A second tick marks the edge on which the flash samples data, so the engine can keep its shift register aligned to the chosen clock phase.

The timing configuration is copied into the block only while the enable input is low. It holds the divisor, polarity, phase, decode mode and the four delays, each counted in reference cycles. While the block is enabled these inputs are ignored. Lowering enable aborts any transfer, releases every select and parks the clock at the polarity level. The minimum select-high time between transfers depends on the next target: when it matches the previous one the same-device gap delay applies, and otherwise the device-switch delay applies.

Top module: `sf_clk_sel_gen`

## Requirements
- R1: Every serial clock half period lasts divisor+1 reference cycles, so a full period is 2 × (divisor+1) cycles, for every 4-bit divisor from 0 to 15.
- R2: The serial clock rests at the polarity bit (0 or 1) whenever no bit is being clocked; the leading edge of each bit moves it away from that level and the trailing edge returns it.
- R3: With decode off, the select output is all ones except bit n low, where n is the low two bits of the target (target 0 gives 1110, target 3 gives 0111, target 1100 gives 1110). The select output only ever changes to or from all ones.
- R4: With decode on, the 4-bit target value appears unchanged on the select output while the select is active.
- R5: The first clock edge follows the select falling by exactly leadDelay+1 reference cycles.
- R6: The select rises exactly tailDelay + 2 × (divisor+1) + 3 reference cycles after the last trailing clock edge.
- R7: When a start is already waiting, a transfer to the same target as the previous one lowers the select exactly gapDelay + 2 × (divisor+1) + 1 cycles after the previous select rise.
- R8: When a start is already waiting, a transfer to a different target lowers the select exactly switchDelay + 2 × (divisor+1) + 1 cycles after the previous select rise.
- R9: bitTick is high for one cycle at every trailing clock edge; xferLast sampled at a trailing edge ends the transfer there, so a transfer of n bits has exactly 2n clock edges.
- R10: sampleTick is high for one cycle at each leading edge when phase is 0, and at each trailing edge when phase is 1, and at no other time.
- R11: idle is high exactly when no transfer is pending or active; it drops in the cycle after a start is accepted, the select is high whenever idle is high, and a start during a transfer is ignored.
- R12: While enable is low, all selects are high, the clock follows the polarity input one cycle later, start is ignored and the select history is cleared; configuration inputs changed while enable is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgEnable | input | 1 | Enable; configuration is loaded while low |
| cfgCpol | input | 1 | Clock resting level |
| cfgCpha | input | 1 | Sample-edge select (0 leading, 1 trailing) |
| cfgBaudDiv | input | 4 | Clock divisor; period 2 × (value+1) |
| cfgDecode | input | 1 | 1 drives the target raw, 0 drives one-hot low |
| cfgLeadDly | input | 8 | Select-low to first clock edge delay |
| cfgTailDly | input | 8 | Last clock edge to select-high delay |
| cfgSwitchDly | input | 8 | Select-high delay before a different target |
| cfgGapDly | input | 8 | Select-high delay before the same target |
| xferStart | input | 1 | One-cycle transfer request |
| xferSelect | input | 4 | Target select value, captured with start |
| xferLast | input | 1 | Current bit is the final bit |
| sclk | output | 1 | Serial clock |
| csN | output | 4 | Active-low select lines |
| idle | output | 1 | No transfer pending or active |
| bitTick | output | 1 | Trailing clock edge strobe |
| sampleTick | output | 1 | Data sample edge strobe |

## Verification
The assertions assume a clean reset at power-up and a polarity input that settles before the edge being checked. They also assume that the engine eventually raises xferLast, so every transfer ends and the idle checks get exercised. The bench changes configuration only through a task that first lowers enable, or on purpose to show that changes made while enabled are ignored. It drives xferLast only after counting bitTick pulses, and it issues each follow-on start in the cycle right after the previous select rise, so the measured high time is the exact minimum the block enforces.

// File: rtl/sf_timing_pkg.sv
package sf_timing_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_LEAD,
    ST_CLOCK,
    ST_TAIL
  } seqState_t;

  // strobes from the sequencer to the timing datapath
  typedef struct packed {
    logic capture;    // take the target select value
    logic csAssert;   // drive the select pattern
    logic csRelease;  // release all selects, start gap timing
    logic loadLead;   // load the lead-in counter
    logic loadTail;   // load the tail counter
    logic cntDec;     // step the delay counter
    logic loadHalf;   // reload the half-period counter
    logic halfDec;    // step the half-period counter
    logic clkLead;    // leading clock edge
    logic clkTrail;   // trailing clock edge
    logic abort;      // block disabled
  } seqStrobe_t;

endpackage

// File: rtl/sf_timing_ctrl.sv
module sf_timing_ctrl
  import sf_timing_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfgEnable,
  input  logic       xferStart,
  input  logic       xferLast,
  input  logic       dlyZero,
  input  logic       halfZero,
  input  logic       gapOk,
  output seqStrobe_t strobe,
  output logic       idle
);

  seqState_t state, nextState;
  logic      afterLead;

  always_comb begin
    strobe    = '0;
    nextState = state;
    if (!cfgEnable) begin
      strobe.abort = 1'b1;
      nextState    = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (xferStart) begin
            strobe.capture = 1'b1;
            nextState      = ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (gapOk) begin
            strobe.csAssert = 1'b1;
            strobe.loadLead = 1'b1;
            nextState       = ST_LEAD;
          end
        end
        ST_LEAD: begin
          if (dlyZero) begin
            strobe.clkLead  = 1'b1;
            strobe.loadHalf = 1'b1;
            nextState       = ST_CLOCK;
          end else begin
            strobe.cntDec = 1'b1;
          end
        end
        ST_CLOCK: begin
          if (!halfZero) begin
            strobe.halfDec = 1'b1;
          end else if (afterLead) begin
            strobe.clkTrail = 1'b1;
            if (xferLast) begin
              strobe.loadTail = 1'b1;
              nextState       = ST_TAIL;
            end else begin
              strobe.loadHalf = 1'b1;
            end
          end else begin
            strobe.clkLead  = 1'b1;
            strobe.loadHalf = 1'b1;
          end
        end
        ST_TAIL: begin
          if (dlyZero) begin
            strobe.csRelease = 1'b1;
            nextState        = ST_IDLE;
          end else begin
            strobe.cntDec = 1'b1;
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      afterLead <= 1'b0;
    end else begin
      state <= nextState;
      if (strobe.abort || strobe.clkTrail) afterLead <= 1'b0;
      else if (strobe.clkLead)             afterLead <= 1'b1;
    end
  end

  assign idle = (state == ST_IDLE);

endmodule

// File: rtl/sf_timing_dp.sv
module sf_timing_dp
  import sf_timing_pkg::*;
#(
  parameter int CS_W  = 4,
  parameter int DIV_W = 4,
  parameter int DLY_W = 8,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgEnable,
  input  logic             cfgCpol,
  input  logic             cfgCpha,
  input  logic [DIV_W-1:0] cfgBaudDiv,
  input  logic             cfgDecode,
  input  logic [DLY_W-1:0] cfgLeadDly,
  input  logic [DLY_W-1:0] cfgTailDly,
  input  logic [DLY_W-1:0] cfgSwitchDly,
  input  logic [DLY_W-1:0] cfgGapDly,
  input  logic [CS_W-1:0]  xferSelect,
  input  seqStrobe_t       strobe,
  output logic             sclk,
  output logic [CS_W-1:0]  csN,
  output logic             bitTick,
  output logic             sampleTick,
  output logic             dlyZero,
  output logic             halfZero,
  output logic             gapOk
);

  localparam int IDX_W = (CS_W > 1) ? $clog2(CS_W) : 1;

  // configuration snapshot, loaded only while disabled
  logic             cpolQ, cphaQ, decQ;
  logic [DIV_W-1:0] divQ;
  logic [DLY_W-1:0] leadQ, tailQ, swQ, gapQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpolQ <= 1'b0;
      cphaQ <= 1'b0;
      decQ  <= 1'b0;
      divQ  <= '0;
      leadQ <= '0;
      tailQ <= '0;
      swQ   <= '0;
      gapQ  <= '0;
    end else if (!cfgEnable) begin
      cpolQ <= cfgCpol;
      cphaQ <= cfgCpha;
      decQ  <= cfgDecode;
      divQ  <= cfgBaudDiv;
      leadQ <= cfgLeadDly;
      tailQ <= cfgTailDly;
      swQ   <= cfgSwitchDly;
      gapQ  <= cfgGapDly;
    end
  end

  logic [CNT_W-1:0] halfLen, periodLen, needHigh, tailLoad;
  logic [CS_W-1:0]  selQ, lastSelQ, oneHotN, csPattern;
  logic [CNT_W-1:0] sinceRise, dlyCnt;
  logic [DIV_W-1:0] halfCnt;
  logic             histValid;

  assign halfLen   = CNT_W'(divQ) + CNT_W'(1);
  assign periodLen = halfLen << 1;
  assign needHigh  = CNT_W'((selQ != lastSelQ) ? swQ : gapQ) + periodLen + CNT_W'(1);
  assign tailLoad  = CNT_W'(tailQ) + periodLen + CNT_W'(2);

  for (genvar g = 0; g < CS_W; g++) begin : gSel
    assign oneHotN[g] = (selQ[IDX_W-1:0] != IDX_W'(g));
  end
  assign csPattern = decQ ? selQ : oneHotN;

  assign gapOk    = !histValid || (sinceRise >= needHigh);
  assign dlyZero  = (dlyCnt == '0);
  assign halfZero = (halfCnt == '0);

  // select history and high-time tracking
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selQ      <= '0;
      lastSelQ  <= '0;
      histValid <= 1'b0;
      sinceRise <= '0;
    end else begin
      if (strobe.capture) selQ <= xferSelect;
      if (strobe.abort) begin
        histValid <= 1'b0;
      end else if (strobe.csRelease) begin
        histValid <= 1'b1;
        lastSelQ  <= selQ;
      end
      if (strobe.csRelease)       sinceRise <= CNT_W'(1);
      else if (sinceRise != '1)   sinceRise <= sinceRise + CNT_W'(1);
    end
  end

  // delay and half-period counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dlyCnt  <= '0;
      halfCnt <= '0;
    end else begin
      if (strobe.loadLead)      dlyCnt <= CNT_W'(leadQ);
      else if (strobe.loadTail) dlyCnt <= tailLoad;
      else if (strobe.cntDec)   dlyCnt <= dlyCnt - CNT_W'(1);
      if (strobe.loadHalf)      halfCnt <= divQ;
      else if (strobe.halfDec)  halfCnt <= halfCnt - DIV_W'(1);
    end
  end

  // registered pin outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk       <= 1'b0;
      csN        <= '1;
      bitTick    <= 1'b0;
      sampleTick <= 1'b0;
    end else begin
      if (strobe.abort)         sclk <= cfgCpol;
      else if (strobe.clkLead)  sclk <= ~cpolQ;
      else if (strobe.clkTrail) sclk <= cpolQ;
      if (strobe.abort || strobe.csRelease) csN <= '1;
      else if (strobe.csAssert)             csN <= csPattern;
      bitTick    <= strobe.clkTrail;
      sampleTick <= cphaQ ? strobe.clkTrail : strobe.clkLead;
    end
  end

endmodule

// File: rtl/sf_clk_sel_gen.sv
module sf_clk_sel_gen
  import sf_timing_pkg::*;
#(
  parameter int CS_W  = 4,
  parameter int DIV_W = 4,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgEnable,
  input  logic             cfgCpol,
  input  logic             cfgCpha,
  input  logic [DIV_W-1:0] cfgBaudDiv,
  input  logic             cfgDecode,
  input  logic [DLY_W-1:0] cfgLeadDly,
  input  logic [DLY_W-1:0] cfgTailDly,
  input  logic [DLY_W-1:0] cfgSwitchDly,
  input  logic [DLY_W-1:0] cfgGapDly,
  input  logic             xferStart,
  input  logic [CS_W-1:0]  xferSelect,
  input  logic             xferLast,
  output logic             sclk,
  output logic [CS_W-1:0]  csN,
  output logic             idle,
  output logic             bitTick,
  output logic             sampleTick
);

  // room for delay + two half periods + padding
  localparam int WIDE  = (DLY_W > DIV_W + 1) ? DLY_W : DIV_W + 1;
  localparam int CNT_W = WIDE + 2;

  seqStrobe_t strobe;
  logic       dlyZero, halfZero, gapOk;

  sf_timing_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfgEnable (cfgEnable),
    .xferStart (xferStart),
    .xferLast  (xferLast),
    .dlyZero   (dlyZero),
    .halfZero  (halfZero),
    .gapOk     (gapOk),
    .strobe    (strobe),
    .idle      (idle)
  );

  sf_timing_dp #(
    .CS_W  (CS_W),
    .DIV_W (DIV_W),
    .DLY_W (DLY_W),
    .CNT_W (CNT_W)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfgEnable    (cfgEnable),
    .cfgCpol      (cfgCpol),
    .cfgCpha      (cfgCpha),
    .cfgBaudDiv   (cfgBaudDiv),
    .cfgDecode    (cfgDecode),
    .cfgLeadDly   (cfgLeadDly),
    .cfgTailDly   (cfgTailDly),
    .cfgSwitchDly (cfgSwitchDly),
    .cfgGapDly    (cfgGapDly),
    .xferSelect   (xferSelect),
    .strobe       (strobe),
    .sclk         (sclk),
    .csN          (csN),
    .bitTick      (bitTick),
    .sampleTick   (sampleTick),
    .dlyZero      (dlyZero),
    .halfZero     (halfZero),
    .gapOk        (gapOk)
  );

endmodule

// File: rtl/sf_timing_chk.sv
module sf_timing_chk #(
  parameter int CS_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfgEnable,
  input logic            cfgCpol,
  input logic            sclk,
  input logic [CS_W-1:0] csN,
  input logic            idle,
  input logic            bitTick
);

  AST_DISABLED_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgEnable |=> (csN == '1)); // R12

  AST_DISABLED_CLK_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgEnable |=> (sclk == $past(cfgCpol))); // R12

  AST_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (csN == '1)); // R11

  AST_CS_VIA_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (csN != $past(csN)) |-> ((csN == '1) || ($past(csN) == '1))); // R3

  AST_TICK_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    bitTick |-> (sclk != $past(sclk))); // R9

  AST_IDLE_CLK_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && $past(idle) && cfgEnable && $past(cfgEnable)) |-> $stable(sclk)); // R2

endmodule

bind sf_clk_sel_gen sf_timing_chk #(.CS_W(CS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfgEnable (cfgEnable),
  .cfgCpol   (cfgCpol),
  .sclk      (sclk),
  .csN       (csN),
  .idle      (idle),
  .bitTick   (bitTick)
);

// File: tb/sf_clk_sel_gen_test.sv
`timescale 1ns/1ps
module sf_clk_sel_gen_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfgEnable = 1'b0, cfgCpol = 1'b0, cfgCpha = 1'b0, cfgDecode = 1'b0;
  logic [3:0] cfgBaudDiv = '0;
  logic [7:0] cfgLeadDly = '0, cfgTailDly = '0, cfgSwitchDly = '0, cfgGapDly = '0;
  logic       xferStart = 1'b0, xferLast = 1'b0;
  logic [3:0] xferSelect = '0;
  logic       sclk, idle, bitTick, sampleTick;
  logic [3:0] csN;

  int checks = 0, errors = 0, cyc = 0, lastRise = 0;
  // expected configuration held by the bench
  int eDiv, eLead, eTail, eSw, eGap;
  bit eCpol, eCpha, eDec;

  sf_clk_sel_gen uut (
    .clk(clk), .rst_n(rst_n), .cfgEnable(cfgEnable), .cfgCpol(cfgCpol),
    .cfgCpha(cfgCpha), .cfgBaudDiv(cfgBaudDiv), .cfgDecode(cfgDecode),
    .cfgLeadDly(cfgLeadDly), .cfgTailDly(cfgTailDly), .cfgSwitchDly(cfgSwitchDly),
    .cfgGapDly(cfgGapDly), .xferStart(xferStart), .xferSelect(xferSelect),
    .xferLast(xferLast), .sclk(sclk), .csN(csN), .idle(idle),
    .bitTick(bitTick), .sampleTick(sampleTick)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic configure(input bit pol, input bit pha, input int dv, input int ld,
                           input int tl, input int sw, input int gp, input bit dec);
    cfgEnable = 1'b0;
    cfgCpol = pol; cfgCpha = pha; cfgBaudDiv = 4'(dv); cfgDecode = dec;
    cfgLeadDly = 8'(ld); cfgTailDly = 8'(tl); cfgSwitchDly = 8'(sw); cfgGapDly = 8'(gp);
    eCpol = pol; eCpha = pha; eDiv = dv; eLead = ld; eTail = tl; eSw = sw; eGap = gp; eDec = dec;
    @(negedge clk); @(negedge clk);
    chk(sclk == pol, "R2 clock parked at polarity", int'(sclk), int'(pol));
    chk(csN == 4'hF && idle, "R12 disabled selects high", int'(csN), 15);
    cfgEnable = 1'b1;
    @(negedge clk);
  endtask

  // one transfer; caller is at a negedge; expGap < 0 skips the gap check
  task automatic runXfer(input int nbits, input logic [3:0] sel, input int expGap, input bit poke);
    int tFall = -1, tFirst = -1, tLast = -1, tRise = -1, edges = 0, ticks = 0, prevEdge = 0;
    int h = eDiv + 1;
    bit badHalf = 0, badTick = 0, badCs = 0, badIdle = 0, lead;
    logic prevS;
    logic [3:0] expCs = eDec ? sel : ~(4'b0001 << sel[1:0]);
    xferSelect = sel; xferStart = 1'b1; xferLast = (nbits == 1);
    @(negedge clk);
    xferStart = 1'b0;
    chk(idle == 1'b0, "R11 idle drops after start", int'(idle), 0);
    prevS = sclk;
    chk(sclk == eCpol, "R2 clock rests at polarity before transfer", int'(sclk), int'(eCpol));
    for (int i = 0; i < 20000; i++) begin
      if (csN != 4'hF) begin
        if (tFall < 0) tFall = cyc;
        if (csN != expCs) badCs = 1;
        if (idle) badIdle = 1;
      end
      if (sclk != prevS) begin
        lead = (sclk != eCpol);
        if (edges == 0) tFirst = cyc;
        else if (cyc - prevEdge != h) badHalf = 1;
        prevEdge = cyc;
        edges++;
        if (sampleTick != (lead ? !eCpha : eCpha)) badTick = 1;
        if (bitTick != !lead) badTick = 1;
        if (!lead) begin
          ticks++;
          tLast = cyc;
          if (ticks == nbits - 1) xferLast = 1'b1;
        end
        xferStart = (poke && edges == 1);
      end else begin
        if (sampleTick || bitTick) badTick = 1;
        xferStart = 1'b0;
      end
      if (tFall >= 0 && csN == 4'hF) begin
        tRise = cyc;
        break;
      end
      prevS = sclk;
      @(negedge clk);
    end
    xferStart = 1'b0;
    xferLast = 1'b0;
    chk(tRise >= 0, "R11 transfer completes", tRise, 0);
    chk(tFirst - tFall == eLead + 1, "R5 lead-in spacing", tFirst - tFall, eLead + 1);
    chk(!badHalf, "R1 half period", int'(badHalf), 0);
    chk(tRise - tLast == eTail + 2 * h + 3, "R6 tail spacing", tRise - tLast, eTail + 2 * h + 3);
    chk(edges == 2 * nbits, "R9 edge count", edges, 2 * nbits);
    chk(ticks == nbits, "R9 bit ticks", ticks, nbits);
    chk(!badTick, "R10 sample tick placement", int'(badTick), 0);
    chk(!badCs, eDec ? "R4 raw select value" : "R3 one-hot select value", int'(badCs), 0);
    chk(!badIdle && idle, "R11 idle tracks transfer", int'(badIdle), 0);
    if (expGap >= 0)
      chk(tFall - lastRise == expGap, (sel == lastSelB) ? "R7 same-target gap" : "R8 switch gap",
          tFall - lastRise, expGap);
    lastRise = tRise;
    lastSelB = sel;
  endtask

  logic [3:0] lastSelB = '0;

  task automatic testReset();
    @(negedge clk);
    chk(csN == 4'hF, "R12 reset selects high", int'(csN), 15);
    chk(idle == 1'b1, "R11 reset idle", int'(idle), 1);
    chk(sclk == 1'b0, "R2 reset clock level", int'(sclk), 0);
  endtask

  task automatic testDividerSweep();
    for (int d = 0; d < 16; d++) begin
      configure(d[0], d[1], d, d, d % 3, 5, 1, 1'b0);
      runXfer(3, 4'(d % 4), -1, 1'b0);
      runXfer(2, 4'(d % 4), eGap + 2 * (eDiv + 1) + 1, 1'b0);
    end
  endtask

  task automatic testSwitch();
    configure(1'b0, 1'b1, 2, 3, 1, 9, 2, 1'b0);
    runXfer(2, 4'd1, -1, 1'b0);
    runXfer(2, 4'd2, eSw + 2 * 3 + 1, 1'b0);
    runXfer(1, 4'd2, eGap + 2 * 3 + 1, 1'b0);
    runXfer(2, 4'b1100, eSw + 2 * 3 + 1, 1'b0); // R3: low bits 00 -> 1110
  endtask

  task automatic testDecode();
    configure(1'b1, 1'b0, 1, 2, 2, 4, 0, 1'b1);
    runXfer(2, 4'b1010, -1, 1'b0);
    runXfer(2, 4'b0110, eSw + 2 * 2 + 1, 1'b0);
  endtask

  task automatic testBusyStart();
    bit stray = 0;
    configure(1'b0, 1'b0, 0, 1, 0, 0, 0, 1'b0);
    runXfer(4, 4'd3, -1, 1'b1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (csN != 4'hF || !idle) stray = 1;
    end
    chk(!stray, "R11 start during transfer ignored", int'(stray), 0);
  endtask

  task automatic testFrozen();
    configure(1'b1, 1'b1, 2, 4, 3, 0, 0, 1'b0);
    cfgBaudDiv = 4'd9; cfgLeadDly = 8'd100; cfgTailDly = 8'd50; cfgCpol = 1'b0;
    @(negedge clk);
    runXfer(3, 4'd0, -1, 1'b0); // R12: old settings must still apply
  endtask

  task automatic testAbort();
    bit stray = 0;
    configure(1'b1, 1'b0, 3, 20, 5, 0, 0, 1'b0);
    xferSelect = 4'd1; xferStart = 1'b1;
    @(negedge clk);
    xferStart = 1'b0;
    for (int i = 0; i < 100 && csN == 4'hF; i++) @(negedge clk);
    chk(csN == 4'b1101, "R3 select 1 gives 1101", int'(csN), 13);
    cfgEnable = 1'b0; cfgCpol = 1'b0;
    @(negedge clk);
    chk(csN == 4'hF, "R12 disable releases selects", int'(csN), 15);
    chk(sclk == 1'b0, "R12 clock follows polarity while disabled", int'(sclk), 0);
    chk(idle == 1'b1, "R12 disable returns idle", int'(idle), 1);
    xferStart = 1'b1;
    @(negedge clk);
    xferStart = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (csN != 4'hF || !idle) stray = 1;
    end
    chk(!stray, "R12 start ignored while disabled", int'(stray), 0);
    configure(1'b1, 1'b0, 3, 2, 1, 200, 200, 1'b0);
    runXfer(1, 4'd1, -1, 1'b0);
  endtask

  task automatic testMaxDelays();
    configure(1'b0, 1'b1, 15, 255, 255, 255, 255, 1'b0);
    runXfer(2, 4'd2, -1, 1'b0);
    runXfer(1, 4'd2, 255 + 32 + 1, 1'b0);
    runXfer(1, 4'd0, 255 + 32 + 1, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testDividerSweep();
    testSwitch();
    testDecode();
    testBusyStart();
    testFrozen();
    testAbort();
    testMaxDelays();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule